// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Unit

This block keeps the interrupt state of one 8-bit timer. The timer has three event sources: counter overflow, compare match on channel A and compare match on channel B. The timer core sends each event as a single-cycle strobe. The block latches every strobe into a sticky pending flag. Next to each flag it keeps an enable bit, and it drives one interrupt request line per source. A request is high only while the processor's global interrupt enable, the source's enable bit and its pending flag are all set.

Software reaches the two 8-bit registers, pending and enable, through a small register port. The port has a one-bit register select, a write strobe, write data and combinational read data. A pending flag can be cleared in two ways:
- software writes a one to its bit, or
- the interrupt controller pulses that source's acknowledge line when it takes the vector.

If an event arrives in the same cycle as a clear, the event is kept.

Top module: `tmr_irq_unit`

## Requirements
- R1: Register select 0 reads the pending register and select 1 reads the enable register. In both registers, bit 0 is overflow, bit 1 is compare A and bit 2 is compare B. The same order applies to `evt`, `vec_ack` and `irq_req`.
- R2: Bits 7 to 3 of both registers always read as zero, and writing them has no effect.
- R3: After a synchronous reset, every pending and enable bit is zero and no request is raised.
- R4: An event strobe sets its pending flag at the next rising edge, and the flag stays set until it is cleared.
- R5: Writing a one to a pending bit clears that flag at the next edge. Writing a zero leaves the flag unchanged.
- R6: An acknowledge strobe on a source clears that source's pending flag at the next edge.
- R7: `irq_req[i]` is high exactly when `glob_ie`, enable bit i and pending flag i are all one.
- R8: Enable bits are plain read/write storage. Writing them never changes a pending flag.
- R9: When an event and a clear (a write of one, an acknowledge, or both) hit the same flag in one cycle, the flag ends up set.
- R10: Reads are combinational and have no side effects. Repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 selects pending, 1 selects enable |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the selected register |
| glob_ie | input | 1 | Global interrupt enable |
| evt | input | 3 | Event strobes: overflow, compare A, compare B |
| vec_ack | input | 3 | Vector-taken acknowledge per source |
| irq_req | output | 3 | Interrupt request per source |

## Verification
A flag's set path and its clear paths can act in the same cycle. The bench provokes this by pulsing an event strobe together with a write-one to the pending register. It also pulses an event together with that source's acknowledge, and with both clears at once. Each case is judged by reading the pending register on the following cycle: the flag must be set and its request must follow the enable and global bits. Single-path clears run on neighbouring bits in the same cycle, to show that each clear reaches only its own bit.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int REG_W    = 8;
    localparam int NSRC     = 3;
    localparam int SRC_OVF  = 0;
    localparam int SRC_CMPA = 1;
    localparam int SRC_CMPB = 2;
    localparam int PAD_W    = REG_W - NSRC;

    typedef enum logic {
        SEL_PEND = 1'b0,
        SEL_ENAB = 1'b1
    } reg_sel_e;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [REG_W-1:0] reg_word_t;

    typedef struct packed {
        src_vec_t set;
        src_vec_t clr;
    } flag_ctl_t;

    function automatic reg_word_t pad_word(input src_vec_t v);
        return {{PAD_W{1'b0}}, v};
    endfunction
endpackage

// File: rtl/tmr_irq_flag_cell.sv
module tmr_irq_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // a set in the same cycle as a clear keeps the flag
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/tmr_irq_enab_reg.sv
module tmr_irq_enab_reg
    import tmr_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  src_vec_t data_i,
    output src_vec_t enab_o
);
    always_ff @(posedge clk) begin
        if (rst)
            enab_o <= '0;
        else if (wr_i)
            enab_o <= data_i;
    end
endmodule

// File: rtl/tmr_irq_rd_mux.sv
module tmr_irq_rd_mux
    import tmr_irq_pkg::*;
(
    input  reg_sel_e  sel_i,
    input  src_vec_t  pend_i,
    input  src_vec_t  enab_i,
    output reg_word_t rd_o
);
    always_comb begin
        unique case (sel_i)
            SEL_PEND: rd_o = pad_word(pend_i);
            SEL_ENAB: rd_o = pad_word(enab_i);
            default:  rd_o = '0;
        endcase
    end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             glob_ie,
    input  logic [NSRC-1:0]  evt,
    input  logic [NSRC-1:0]  vec_ack,
    output logic [NSRC-1:0]  irq_req
);
    reg_sel_e  sel;
    flag_ctl_t ctl;
    src_vec_t  flag_q;
    src_vec_t  mask_q;
    logic      wr_pend;
    logic      wr_enab;

    assign sel     = reg_sel_e'(reg_sel);
    assign wr_pend = wr_en && (sel == SEL_PEND);
    assign wr_enab = wr_en && (sel == SEL_ENAB);

    always_comb begin
        ctl.set = evt;
        ctl.clr = vec_ack | ({NSRC{wr_pend}} & wr_data[NSRC-1:0]);
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        tmr_irq_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (ctl.set[i]),
            .clr_i  (ctl.clr[i]),
            .flag_o (flag_q[i])
        );
    end

    tmr_irq_enab_reg u_enab (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr_enab),
        .data_i (wr_data[NSRC-1:0]),
        .enab_o (mask_q)
    );

    tmr_irq_rd_mux u_rd (
        .sel_i  (sel),
        .pend_i (flag_q),
        .enab_i (mask_q),
        .rd_o   (rd_data)
    );

    assign irq_req = flag_q & mask_q & {NSRC{glob_ie}};
endmodule

// File: rtl/tmr_irq_unit_chk.sv
module tmr_irq_unit_chk
    import tmr_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_sel,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             glob_ie,
    input logic [NSRC-1:0]  evt,
    input logic [NSRC-1:0]  vec_ack,
    input logic [NSRC-1:0]  irq_req,
    input logic [NSRC-1:0]  flag_q,
    input logic [NSRC-1:0]  mask_q
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1:NSRC] == '0);

    // R3
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flag_q == '0 && mask_q == '0));

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // R4 R9
        evt_set_chk: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> flag_q[i]);

        // R5
        w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && reg_sel == 1'b0 && wr_data[i] && !evt[i]) |=> !flag_q[i]);

        // R6
        ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (vec_ack[i] && !evt[i]) |=> !flag_q[i]);

        // R7
        irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
            irq_req[i] |-> (glob_ie && mask_q[i] && flag_q[i]));

        // R8
        mask_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && reg_sel == 1'b1 && !evt[i] && !vec_ack[i]) |=> $stable(flag_q[i]));
    end
endmodule

bind tmr_irq_unit tmr_irq_unit_chk chk_i (.*);

// File: tb/tmr_irq_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_unit_tb_top;
    typedef struct {
        string      tag;
        logic [7:0] exp_rd;
        logic [2:0] exp_irq;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       glob_ie = 1'b0;
    logic [2:0] evt = '0;
    logic [2:0] vec_ack = '0;
    logic [2:0] irq_req;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    event  obs_ev;
    logic [2:0] m_flag = '0;
    logic [2:0] m_mask = '0;

    always #2.5 clk = ~clk;

    tmr_irq_unit dut_i (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .glob_ie(glob_ie),
        .evt(evt), .vec_ack(vec_ack), .irq_req(irq_req)
    );

    // one clock of stimulus; reference model updated at the edge
    task automatic cyc(input logic [2:0] e, input logic [2:0] a,
                       input logic we, input logic sel, input logic [7:0] wd);
        logic [2:0] clr;
        evt = e; vec_ack = a; wr_en = we; reg_sel = sel; wr_data = wd;
        @(posedge clk);
        clr = a | ((we && !sel) ? wd[2:0] : 3'b000);
        m_flag = e | (m_flag & ~clr);
        if (we && sel) m_mask = wd[2:0];
        #1;
        evt = '0; vec_ack = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    // driver: selects a register and pushes the expected view
    task automatic obs(input logic sel, input string tag);
        item_t it;
        reg_sel = sel;
        it.tag = tag;
        it.exp_rd = {5'b0, sel ? m_mask : m_flag};
        it.exp_irq = m_flag & m_mask & {3{glob_ie}};
        sb_q.push_back(it);
        -> obs_ev;
        #1;
    endtask

    // monitor
    initial begin
        forever begin
            @(obs_ev);
            #0.5;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (rd_data !== it.exp_rd || irq_req !== it.exp_irq) begin
                    n_fail++;
                    $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b",
                             it.tag, rd_data, irq_req, it.exp_rd, it.exp_irq);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        obs(1'b0, "R3 reset pending");
        obs(1'b1, "R3 reset enable");
        // R4 single events, each on its own bit
        cyc(3'b001, 3'b000, 1'b0, 1'b0, 8'h00);
        obs(1'b0, "R4 overflow sets bit0 (R1)");
        cyc(3'b100, 3'b000, 1'b0, 1'b0, 8'h00);
        obs(1'b0, "R4 compare B sets bit2, bit0 sticky (R1)");
        // R8 enable write does not disturb flags; R2 reserved writes ignored
        cyc(3'b000, 3'b000, 1'b1, 1'b1, 8'hFF);
        obs(1'b1, "R2 R8 enable reads 07 after FF write");
        obs(1'b0, "R8 pending unchanged by enable write");
        // R7 gating
        obs(1'b0, "R7 global off, no request");
        glob_ie = 1'b1;
        obs(1'b0, "R7 global on, requests bit0 bit2");
        cyc(3'b000, 3'b000, 1'b1, 1'b1, 8'h04);
        obs(1'b0, "R7 only compare B enabled");
        // R10 repeated reads
        obs(1'b0, "R10 read again");
        obs(1'b0, "R10 read third time");
        // R5 write zero no effect, reserved ones ignored
        cyc(3'b000, 3'b000, 1'b1, 1'b0, 8'hF8);
        obs(1'b0, "R5 R2 zeros and reserved ones keep flags");
        cyc(3'b000, 3'b000, 1'b1, 1'b0, 8'h01);
        obs(1'b0, "R5 write one clears bit0 only");
        // R6 ack clears
        cyc(3'b010, 3'b000, 1'b0, 1'b0, 8'h00);
        cyc(3'b000, 3'b100, 1'b0, 1'b0, 8'h00);
        obs(1'b0, "R6 ack clears compare B, compare A kept");
        // R9 collisions
        cyc(3'b001, 3'b000, 1'b1, 1'b0, 8'h03);
        obs(1'b0, "R9 event vs write-one on bit0, bit1 cleared");
        cyc(3'b100, 3'b100, 1'b0, 1'b0, 8'h00);
        obs(1'b0, "R9 event vs ack on bit2");
        cyc(3'b010, 3'b010, 1'b1, 1'b0, 8'h02);
        obs(1'b0, "R9 event vs both clears on bit1");
        cyc(3'b000, 3'b000, 1'b1, 1'b1, 8'h07);
        obs(1'b0, "R7 all enabled requests");
        obs(1'b1, "R8 enable readback 07");
        // R3 reset mid-run
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        m_flag = '0; m_mask = '0;
        obs(1'b0, "R3 reset clears pending");
        obs(1'b1, "R3 reset clears enable");
        #5;
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule